// File: doc/BRIEF.md
# E1 Per-Timeslot Idle Code and Source Selector

This block chooses, bit by bit, what goes out on the transmit serial line of a 32-timeslot E1 frame. It takes a transmit-side serial stream, a receive-side serial stream, a bit clock and a frame sync pulse. It produces one registered serial output. A 32-bit timeslot mask, an 8-bit idle code and a one-bit mode flag are held in a small register file. Software writes and reads this register file through an address/data port.

The mode flag decides what the mask does. With the flag clear, a set mask bit replaces the whole timeslot with the shared idle code, sent most significant bit first. With the flag set, a set mask bit takes that timeslot from the receive-side stream instead of the transmit stream. A clear mask bit always passes the transmit stream. Each timeslot chooses its source once, at its first bit, and keeps that choice for all eight bits. A register write in the middle of a timeslot therefore never splits a byte.

Top module: `e1_slot_mux`

## Requirements
- R1: Frame position p (0..255) belongs to timeslot p/8+1 and carries bit p%8 of that timeslot. Mask register k (address k, k = 0..3) bit j controls timeslot 8k+j+1. So address 0 bit 0 is timeslot 1 and address 3 bit 7 is timeslot 32.
- R2: A timeslot whose mask bit is 0 outputs the transmit serial input unchanged, in both modes.
- R3: With the mode flag 0, a timeslot whose mask bit is 1 outputs the idle code. Idle code bit 7 goes out at slot bit 0 and idle code bit 0 goes out at slot bit 7. All timeslots use the same idle code.
- R4: The register address map is: addresses 0..3 are the mask registers, address 4 is the idle code, and address 5 holds the mode flag in bit 0 (the other bits read 0). Writes to addresses 6 and 7 have no effect, and those addresses read 0.
- R5: With the mode flag 1, a timeslot whose mask bit is 1 outputs the receive-side serial input.
- R6: The mask bit, mode flag and idle code that apply to a timeslot are those held in the registers at the clock edge of its bit 0. A write at any later bit of that timeslot takes effect from the next timeslot.
- R7: The output bit sampled at a clock edge is the selected data bit from the previous edge. This one-clock latency is the same for the transmit, receive and idle paths.
- R8: A frame sync high at a clock edge makes that bit frame position 0. Without a frame sync, the position advances by one per clock and wraps from 255 to 0. The first clock after reset is position 0.
- R9: Synchronous reset clears all five registers and the mode flag, and drives the serial output and the read data to 0. After reset every timeslot passes the transmit input.
- R10: The read data shows, one clock later, the register selected by the address at the clock edge. A write and a read of the same address in the same clock return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, marks frame position 0 |
| tx_in | input | 1 | Transmit-side serial data |
| rx_in | input | 1 | Receive-side serial data |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ser_out | output | 1 | Registered serial output |

## Verification
A bit or slot counter that is off by one shows as idle or receive data appearing one timeslot early or late. It also shows as an idle byte that comes out rotated. Either fault is visible on the serial output within the eight clocks of the first masked timeslot after a frame sync. A selection that is not held through its timeslot shows as a byte with mixed sources on the first clock after a mid-slot write. A fault in the register file or the mode decode shows on the read data one clock after the address is applied, and on the output at the start of the next masked timeslot.

// File: rtl/e1_slot_pkg.sv
package e1_slot_pkg;
  typedef enum logic [1:0] {
    SRC_TX   = 2'd0,
    SRC_IDLE = 2'd1,
    SRC_RX   = 2'd2
  } src_e;
endpackage

// File: rtl/e1_slot_regs.sv
module e1_slot_regs #(
  parameter int SLOTS  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SLOTS-1:0]  mask,
  output logic [DATA_W-1:0] code,
  output logic              alt_mode,
  output logic [DATA_W-1:0] rdata
);
  localparam int NUM_MASK  = SLOTS / DATA_W;
  localparam int CODE_ADDR = NUM_MASK;
  localparam int MODE_ADDR = NUM_MASK + 1;

  logic [DATA_W-1:0] bank_q [NUM_MASK];
  logic [DATA_W-1:0] code_q;
  logic              mode_q;
  logic [DATA_W-1:0] rd_mux;

  for (genvar g = 0; g < NUM_MASK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                bank_q[g] <= '0;
      else if (we && addr == ADDR_W'(g))      bank_q[g] <= wdata;
    end
    assign mask[g*DATA_W +: DATA_W] = bank_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else if (we) begin
      if (addr == ADDR_W'(CODE_ADDR)) code_q <= wdata;
      if (addr == ADDR_W'(MODE_ADDR)) mode_q <= wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_MASK; i++)
      if (addr == ADDR_W'(i)) rd_mux = bank_q[i];
    if (addr == ADDR_W'(CODE_ADDR)) rd_mux = code_q;
    if (addr == ADDR_W'(MODE_ADDR)) rd_mux = DATA_W'(mode_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign code     = code_q;
  assign alt_mode = mode_q;

  // R4
  mode_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(MODE_ADDR)) |=> (alt_mode == $past(wdata[0])));
endmodule

// File: rtl/e1_slot_timer.sv
module e1_slot_timer #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  output logic [POS_W-1:0] pos
);
  logic [POS_W-1:0] cnt_q;

  assign pos = fsync ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '1;
    else     cnt_q <= pos;
  end

  // R8
  sync_zero_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |=> (cnt_q == '0));
  // R8
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    !fsync |=> (cnt_q == POS_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/e1_slot_sel.sv
module e1_slot_sel
  import e1_slot_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [$clog2(SLOTS)+$clog2(SLOT_W)-1:0] pos,
  input  logic [SLOTS-1:0]                      mask,
  input  logic [SLOT_W-1:0]                     code,
  input  logic                                  alt_mode,
  input  logic                                  tx_in,
  input  logic                                  rx_in,
  output logic                                  ser_out
);
  localparam int BIT_W = $clog2(SLOT_W);
  localparam int IDX_W = $clog2(SLOTS);

  logic [IDX_W-1:0]  slot;
  logic [BIT_W-1:0]  bit_i;
  logic              first;
  src_e              live_src, src_q, eff_src;
  logic [SLOT_W-1:0] code_q, eff_code;
  logic              idle_bit;

  assign slot  = pos[BIT_W +: IDX_W];
  assign bit_i = pos[BIT_W-1:0];
  assign first = (bit_i == '0);

  always_comb begin
    if (!mask[slot])   live_src = SRC_TX;
    else if (alt_mode) live_src = SRC_RX;
    else               live_src = SRC_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_TX;
      code_q <= '0;
    end else if (first) begin
      src_q  <= live_src;
      code_q <= code;
    end
  end

  assign eff_src  = first ? live_src : src_q;
  assign eff_code = first ? code : code_q;
  assign idle_bit = eff_code[BIT_W'(SLOT_W-1) - bit_i];

  always_ff @(posedge clk) begin
    if (rst) ser_out <= 1'b0;
    else begin
      case (eff_src)
        SRC_IDLE: ser_out <= idle_bit;
        SRC_RX:   ser_out <= rx_in;
        default:  ser_out <= tx_in;
      endcase
    end
  end

  // R6
  hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !first |=> ($stable(src_q) && $stable(code_q)));
  // R2
  tx_path_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_src == SRC_TX) |=> (ser_out == $past(tx_in)));
  // R5
  rx_path_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_src == SRC_RX) |=> (ser_out == $past(rx_in)));
endmodule

// File: rtl/e1_slot_mux.sv
module e1_slot_mux #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              tx_in,
  input  logic              rx_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [SLOT_W-1:0] reg_wdata,
  output logic [SLOT_W-1:0] reg_rdata,
  output logic              ser_out
);
  localparam int POS_W = $clog2(SLOTS) + $clog2(SLOT_W);

  logic [POS_W-1:0]  pos;
  logic [SLOTS-1:0]  mask;
  logic [SLOT_W-1:0] code;
  logic              alt_mode;

  e1_slot_regs #(.SLOTS(SLOTS), .DATA_W(SLOT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .mask(mask), .code(code), .alt_mode(alt_mode), .rdata(reg_rdata)
  );

  e1_slot_timer #(.POS_W(POS_W)) u_timer (
    .clk(clk), .rst(rst), .fsync(fsync), .pos(pos)
  );

  e1_slot_sel #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_sel (
    .clk(clk), .rst(rst), .pos(pos), .mask(mask), .code(code),
    .alt_mode(alt_mode), .tx_in(tx_in), .rx_in(rx_in), .ser_out(ser_out)
  );
endmodule

// File: tb/e1_slot_mux_tb.sv
`timescale 1ns/100ps
module e1_slot_mux_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b0, tx_in = 1'b0, rx_in = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ser_out;

  int    checks = 0, failures = 0, cycles = 0;
  string phase = "R9 reset";
  bit    done = 0;

  e1_slot_mux u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .tx_in(tx_in), .rx_in(rx_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ser_out(ser_out)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int         m_pos, m_src, m_slot, m_bit;
  logic [7:0] m_mask [4];
  logic [7:0] m_code, m_codeq;
  logic       m_mode, exp_out;
  logic [7:0] exp_rd;

  function automatic logic [7:0] m_read(input logic [2:0] a);
    if (a < 3'd4)  return m_mask[a[1:0]];
    if (a == 3'd4) return m_code;
    if (a == 3'd5) return {7'b0, m_mode};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_pos = 255; m_src = 0; m_code = 0; m_codeq = 0; m_mode = 0;
      for (int i = 0; i < 4; i++) m_mask[i] = 0;
      exp_out = 0; exp_rd = 0;
    end else begin
      m_pos  = fsync ? 0 : (m_pos + 1) % 256;
      m_slot = m_pos / 8;
      m_bit  = m_pos % 8;
      if (m_bit == 0) begin
        m_src   = m_mask[m_slot / 8][m_slot % 8] ? (m_mode ? 2 : 1) : 0;
        m_codeq = m_code;
      end
      exp_out = (m_src == 0) ? tx_in : (m_src == 2) ? rx_in : m_codeq[7 - m_bit];
      exp_rd  = m_read(reg_addr);
      if (reg_we) begin
        if (reg_addr < 3'd4)       m_mask[reg_addr[1:0]] = reg_wdata;
        else if (reg_addr == 3'd4) m_code = reg_wdata;
        else if (reg_addr == 3'd5) m_mode = reg_wdata[0];
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      string tag;
      tag = (m_src == 0) ? "R2" : (m_src == 2) ? "R5" : "R3";
      checks++;
      if (ser_out !== exp_out) begin
        failures++;
        $display("FAIL %s [%s R7] ser_out pos=%0d act=%b exp=%b", tag, phase, m_pos, ser_out, exp_out);
      end
      checks++;
      if (reg_rdata !== exp_rd) begin
        failures++;
        $display("FAIL R10 [%s] reg_rdata act=%h exp=%h", phase, reg_rdata, exp_rd);
      end
    end
  end

  task automatic step(input bit fs);
    @(negedge clk); #1;
    fsync = fs; tx_in = 1'($urandom); rx_in = 1'($urandom); reg_we = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    fsync = 0; tx_in = 1'($urandom); rx_in = 1'($urandom);
    reg_we = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n * 256; i++) step(i % 256 == 0);
  endtask

  task automatic direct(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    direct("R9 ser_out in reset", {7'b0, ser_out}, 8'h00);
    direct("R9 rdata in reset", reg_rdata, 8'h00);
    #1 rst = 0;

    phase = "R9 R2 R8 passthrough after reset";
    run_frames(1);

    phase = "R1 R3 R4 idle code map";
    wr(3'd0, 8'h01); wr(3'd3, 8'h80); wr(3'd4, 8'hA5); wr(3'd1, 8'h30);
    run_frames(2);

    phase = "R5 R2 alternate source";
    wr(3'd5, 8'hFF); wr(3'd2, 8'h5A);
    run_frames(2);

    phase = "R6 mid-slot writes";
    for (int i = 0; i < 512; i++) begin
      if (i % 256 == 0) step(1);
      else if ($urandom % 3 == 0) wr(3'($urandom % 6), 8'($urandom));
      else step(0);
    end

    phase = "R8 wrap and realign";
    wr(3'd5, 8'h00); wr(3'd0, 8'hFF); wr(3'd4, 8'h3C);
    for (int i = 0; i < 300; i++) step(0);
    step(1);
    for (int i = 0; i < 77; i++) step(0);
    step(1);
    for (int i = 0; i < 100; i++) step(0);

    phase = "R4 R10 readback and unused addresses";
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); #1; reg_we = 0; reg_addr = 3'(a);
    end
    wr(3'd4, 8'h99);
    wr(3'd4, 8'h11);
    run_frames(1);

    phase = "R9 reset clears registers";
    @(negedge clk); #1 rst = 1;
    repeat (2) @(negedge clk);
    #1 rst = 0;
    for (int a = 0; a < 6; a++) begin
      @(negedge clk); #1; reg_we = 0; reg_addr = 3'(a);
      @(negedge clk);
      direct("R9 register cleared", reg_rdata, 8'h00);
    end
    run_frames(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    done = 1;
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule